// File: doc/BRIEF.md
# Cycle and System Tick Counters with Compare Interrupts

This block keeps time for a processor core. It holds two 64-bit counters. The cycle counter advances on every core clock. The system counter advances only on cycles where a fixed-rate enable pulse arrives, so its rate does not change when the core clock is throttled. In each counter, the top bit is a trap enable for non-privileged access and the low 63 bits are the count. Each counter has its own 64-bit compare register. In a compare register, the top bit disables the interrupt and the low 63 bits hold the match value. When a counter update lands on the match value, a sticky pending bit is set and drives that counter's interrupt request.

Software reaches the four registers through a one-request-per-cycle access port. A request carries a register index, a write flag, write data and a privilege level. The port returns read data, or a one-cycle trap indication, on the cycle after the request. Each pending bit is cleared through its own clear strobe, which acts only while the privilege input is high. The block does not deliver traps, route interrupts or generate the tick pulse.

Top module: `cycle_timer`

## Requirements
- R1: After reset, each counter holds the top bit 1 with a count of 0. Each compare register holds the disable bit 1 with a value of 0. trap_o and irq_o are low.
- R2: Each clock cycle, the cycle counter (index 0) adds 1 to its low 63 bits and leaves bit 63 unchanged.
- R3: The system counter (index 2) adds 1 only in cycles where sys_tick_i is 1. Otherwise it holds its value.
- R4: The 63-bit count wraps from all ones to zero, and bit 63 keeps its value.
- R5: A privileged write to a counter loads all 64 bits. A write takes priority over an increment in the same cycle.
- R6: A read request returns, on rdata_o one cycle later, the register's value from before that clock edge. Index encoding is 0 cycle count, 1 cycle compare, 2 system count, 3 system compare. A privileged read returns all 64 bits. rdata_o is 0 in cycles that follow no returning read.
- R7: A non-privileged read of a counter whose bit 63 is 1 sets trap_o for one cycle and returns 0. With bit 63 at 0, the read returns the data with no trap. Compare registers are readable at either privilege level.
- R8: A non-privileged write to any of the four registers changes nothing and sets trap_o for one cycle.
- R9: When a counter update (increment or write) produces a 63-bit count equal to its compare value while the compare's bit 63 is 0, the pair's pending bit is set. irq_o[0] belongs to the cycle pair and irq_o[1] to the system pair.
- R10: While the compare's bit 63 is 1, a match never sets the pending bit.
- R11: A pending bit stays set until clr_i for that pair is asserted while priv_i is 1. Rewriting the compare register does not clear it, and a clear without privilege is ignored. A match and a clear in the same cycle leave the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sys_tick_i | input | 1 | Fixed-rate single-cycle enable for the system counter |
| req_i | input | 1 | Access request valid |
| we_i | input | 1 | 1 = write, 0 = read |
| idx_i | input | 2 | Register index (0 cyc cnt, 1 cyc cmp, 2 sys cnt, 3 sys cmp) |
| priv_i | input | 1 | 1 = privileged access |
| wdata_i | input | 64 | Write data |
| clr_i | input | 2 | Per-pair pending clear strobe, honoured only with priv_i |
| rdata_o | output | 64 | Read data, one cycle after the request |
| trap_o | output | 1 | Access trap, one cycle after the request |
| irq_o | output | 2 | Pending compare interrupts |

## Verification
A behavioural model in the bench is compared against every output on every cycle.

The stimulus covers several patterns:
- Free counting separates the every-cycle counter from the gated one.
- Irregular tick pulse patterns show whether the system counter follows only its enable.
- Writes that land in the same cycle as increments, and counts loaded just below the wrap point, expose priority mistakes and errors in how bit 63 is carried.
- Match scenarios with the interrupt disabled, with the compare rewritten after a hit, and with clears at both privilege levels separate the sticky, gating and clear paths.
- Non-privileged accesses are tried against counters with bit 63 set and clear to separate the trap rules from the read data path.

// File: rtl/cycle_timer_pkg.sv
package cycle_timer_pkg;
  localparam int NUM_TMR = 2;
  localparam int IDX_W   = $clog2(2 * NUM_TMR);

  typedef enum logic [IDX_W-1:0] {
    IDX_CYC_CNT = 2'd0,
    IDX_CYC_CMP = 2'd1,
    IDX_SYS_CNT = 2'd2,
    IDX_SYS_CMP = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/timer_counter.sv
module timer_counter #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         wr_cnt_i,
  input  logic         wr_cmp_i,
  input  logic [W-1:0] wdata_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cmp_o,
  output logic         pend_o
);
  localparam logic [W-2:0] ONE = {{(W-2){1'b0}}, 1'b1};
  localparam logic [W-1:0] RST_VAL = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] cnt_q, cmp_q, cnt_d;
  logic         pend_q, upd, hit;

  always_comb begin
    if (wr_cnt_i)   cnt_d = wdata_i;
    else if (inc_i) cnt_d = {cnt_q[W-1], cnt_q[W-2:0] + ONE};
    else            cnt_d = cnt_q;
    upd = wr_cnt_i | inc_i;
    // match is taken on the value being loaded, against the compare in force
    hit = upd && (cnt_d[W-2:0] == cmp_q[W-2:0]) && !cmp_q[W-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= RST_VAL;
      cmp_q  <= RST_VAL;
      pend_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (wr_cmp_i) cmp_q <= wdata_i;
      pend_q <= hit | (pend_q & ~clr_i);
    end
  end

  assign cnt_o  = cnt_q;
  assign cmp_o  = cmp_q;
  assign pend_o = pend_q;

  assert_inc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_cnt_i) |=> cnt_q[W-2:0] == $past(cnt_q[W-2:0]) + ONE);
  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !wr_cnt_i) |=> $stable(cnt_q));
  assert_top_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_cnt_i |=> cnt_q[W-1] == $past(cnt_q[W-1]));
  assert_write_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt_i |=> cnt_q == $past(wdata_i));
  assert_disable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> !$past(cmp_q[W-1]));
  assert_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !clr_i) |=> pend_q);
endmodule

// File: rtl/timer_reg_port.sv
module timer_reg_port
  import cycle_timer_pkg::*;
#(
  parameter int W = 64
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_i,
  input  logic                      we_i,
  input  logic [IDX_W-1:0]          idx_i,
  input  logic                      priv_i,
  input  logic [NUM_TMR-1:0]        clr_i,
  input  logic [NUM_TMR-1:0][W-1:0] cnt_i,
  input  logic [NUM_TMR-1:0][W-1:0] cmp_i,
  output logic [NUM_TMR-1:0]        wr_cnt_o,
  output logic [NUM_TMR-1:0]        wr_cmp_o,
  output logic [NUM_TMR-1:0]        clr_o,
  output logic [W-1:0]              rdata_o,
  output logic                      trap_o
);
  logic [W-1:0] sel;
  logic         is_cmp, wr_ok, rd_trap, wr_trap, rd_ok;
  logic [IDX_W-2:0] tmr;

  assign is_cmp = idx_i[0];
  assign tmr    = idx_i[IDX_W-1:1];
  assign wr_ok  = req_i & we_i & priv_i;

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_dec
    assign wr_cnt_o[t] = wr_ok && !is_cmp && (tmr == t[IDX_W-2:0]);
    assign wr_cmp_o[t] = wr_ok &&  is_cmp && (tmr == t[IDX_W-2:0]);
    assign clr_o[t]    = clr_i[t] & priv_i;
  end

  always_comb begin
    sel     = is_cmp ? cmp_i[tmr] : cnt_i[tmr];
    rd_trap = req_i && !we_i && !priv_i && !is_cmp && sel[W-1];
    wr_trap = req_i && we_i && !priv_i;
    rd_ok   = req_i && !we_i && !rd_trap;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      trap_o  <= 1'b0;
    end else begin
      rdata_o <= rd_ok ? sel : '0;
      trap_o  <= rd_trap | wr_trap;
    end
  end

  assert_trap_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> rdata_o == '0);
  assert_np_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !priv_i) |=> trap_o);
  assert_np_nowrite_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !priv_i |-> (wr_cnt_o == '0 && wr_cmp_o == '0));
  assert_trap_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !trap_o);
endmodule

// File: rtl/cycle_timer.sv
module cycle_timer
  import cycle_timer_pkg::*;
#(
  parameter int W = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sys_tick_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic               priv_i,
  input  logic [W-1:0]       wdata_i,
  input  logic [NUM_TMR-1:0] clr_i,
  output logic [W-1:0]       rdata_o,
  output logic               trap_o,
  output logic [NUM_TMR-1:0] irq_o
);
  logic [NUM_TMR-1:0][W-1:0] cnt, cmp;
  logic [NUM_TMR-1:0]        inc, wr_cnt, wr_cmp, clr, pend;

  assign inc = {sys_tick_i, 1'b1};

  timer_reg_port #(.W(W)) u_port (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .idx_i    (idx_i),
    .priv_i   (priv_i),
    .clr_i    (clr_i),
    .cnt_i    (cnt),
    .cmp_i    (cmp),
    .wr_cnt_o (wr_cnt),
    .wr_cmp_o (wr_cmp),
    .clr_o    (clr),
    .rdata_o  (rdata_o),
    .trap_o   (trap_o)
  );

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    timer_counter #(.W(W)) u_tmr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .inc_i    (inc[t]),
      .wr_cnt_i (wr_cnt[t]),
      .wr_cmp_i (wr_cmp[t]),
      .wdata_i  (wdata_i),
      .clr_i    (clr[t]),
      .cnt_o    (cnt[t]),
      .cmp_o    (cmp[t]),
      .pend_o   (pend[t])
    );
  end

  assign irq_o = pend;

  assert_irq_reset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> irq_o == '0);
  assert_clr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o[0]) |-> $past(clr_i[0] && priv_i));
endmodule

// File: tb/cycle_timer_bench.sv
module cycle_timer_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sys_tick_i = 1'b0, req_i = 1'b0, we_i = 1'b0, priv_i = 1'b0;
  logic [1:0]  idx_i = 2'd0, clr_i = 2'd0;
  logic [63:0] wdata_i = 64'd0;
  logic [63:0] rdata_o;
  logic        trap_o;
  logic [1:0]  irq_o;

  int total = 0, bad = 0, wd = 0;
  string phase = "R1";

  logic [63:0] m_cnt [2];
  logic [63:0] m_cmp [2];
  logic [1:0]  m_pend;
  logic [63:0] e_rd;
  logic        e_trap;

  cycle_timer u_cycle_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .sys_tick_i(sys_tick_i), .req_i(req_i),
    .we_i(we_i), .idx_i(idx_i), .priv_i(priv_i), .wdata_i(wdata_i),
    .clr_i(clr_i), .rdata_o(rdata_o), .trap_o(trap_o), .irq_o(irq_o)
  );

  always #2 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    wd++;
    if (wd > 20000) begin
      bad++;
      $display("FAIL watchdog act=%0d exp<=20000", wd);
      $display("test done: total=%0d bad=%0d", total + 1, bad);
      $finish;
    end
  end

  task automatic chk64(input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", phase, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk64("rdata", rdata_o, e_rd);
    chk64("trap", {63'd0, trap_o}, {63'd0, e_trap});
    chk64("irq", {62'd0, irq_o}, {62'd0, m_pend});
  endtask

  // check outputs, drive inputs, advance model, wait for next negedge
  task automatic step(input logic rq, input logic w, input logic [1:0] ix,
                      input logic pv, input logic [63:0] wd_v,
                      input logic tk, input logic [1:0] cl);
    logic [63:0] sel, nc;
    logic        inc, wr, hit;
    compare_all();
    req_i = rq; we_i = w; idx_i = ix; priv_i = pv; wdata_i = wd_v;
    sys_tick_i = tk; clr_i = cl;
    e_rd = 64'd0; e_trap = 1'b0;
    sel = ix[0] ? m_cmp[ix[1]] : m_cnt[ix[1]];
    if (rq && w && !pv) e_trap = 1'b1;
    if (rq && !w) begin
      if (!pv && !ix[0] && sel[63]) e_trap = 1'b1;
      else e_rd = sel;
    end
    for (int t = 0; t < 2; t++) begin
      inc = (t == 0) ? 1'b1 : tk;
      wr  = rq && w && pv && (ix == 2'(2 * t));
      if (wr) nc = wd_v;
      else if (inc) nc = {m_cnt[t][63], m_cnt[t][62:0] + 63'd1};
      else nc = m_cnt[t];
      hit = (wr || inc) && (nc[62:0] == m_cmp[t][62:0]) && !m_cmp[t][63];
      m_pend[t] = hit | (m_pend[t] & ~(cl[t] & pv));
      m_cnt[t] = nc;
      if (rq && w && pv && (ix == 2'(2 * t + 1))) m_cmp[t] = wd_v;
    end
    @(negedge clk_i);
  endtask

  task automatic idle(input int n, input logic tk);
    for (int i = 0; i < n; i++) step(0, 0, 0, 1, 0, tk, 0);
  endtask

  task automatic rd(input logic [1:0] ix, input logic pv);
    step(1, 0, ix, pv, 0, 0, 0);
  endtask

  task automatic wr(input logic [1:0] ix, input logic pv, input logic [63:0] v);
    step(1, 1, ix, pv, v, 0, 0);
  endtask

  initial begin
    for (int t = 0; t < 2; t++) begin
      m_cnt[t] = 64'h8000_0000_0000_0000;
      m_cmp[t] = 64'h8000_0000_0000_0000;
    end
    m_pend = 2'b00; e_rd = 64'd0; e_trap = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    phase = "R1";
    rd(0, 1);
    chk64("R1 cyc reset", rdata_o, 64'h8000_0000_0000_0000);
    rd(1, 1); rd(2, 1); rd(3, 1);
    idle(1, 0);

    phase = "R2";
    idle(5, 0); rd(0, 1); idle(1, 0);

    phase = "R3";
    step(0, 0, 0, 1, 0, 1, 0); idle(2, 0);
    idle(2, 1); idle(1, 0);
    step(1, 0, 2, 1, 0, 1, 0); rd(2, 1); idle(1, 0);

    phase = "R5";
    wr(0, 1, 64'h0000_0000_0000_1000); rd(0, 1);
    step(1, 1, 2, 1, 64'h0000_0000_0000_0040, 1, 0); rd(2, 1); idle(1, 0);

    phase = "R4";
    wr(0, 1, 64'h7FFF_FFFF_FFFF_FFFE); idle(2, 0); rd(0, 1);
    wr(2, 1, 64'hFFFF_FFFF_FFFF_FFFF); idle(1, 1); rd(2, 1); idle(1, 0);

    phase = "R6";
    wr(1, 1, 64'h1234_5678_9ABC_DEF0); rd(1, 1);
    wr(3, 1, 64'h0FED_CBA9_8765_4321); rd(3, 1); idle(1, 0);

    phase = "R7";
    rd(0, 0);
    rd(2, 0);
    rd(1, 0); rd(3, 0);
    wr(0, 1, 64'h8000_0000_0000_0005); rd(0, 0); idle(1, 0);

    phase = "R8";
    wr(0, 0, 64'h1); wr(1, 0, 64'h2); wr(2, 0, 64'h3); wr(3, 0, 64'h4);
    rd(0, 1); rd(1, 1); rd(2, 1); rd(3, 1); idle(1, 0);

    phase = "R9";
    wr(1, 1, 64'd105); wr(0, 1, 64'd100); idle(8, 0);
    wr(3, 1, 64'd3); wr(2, 1, 64'd0); idle(1, 1); idle(2, 0); idle(2, 1); idle(2, 0);

    phase = "R11";
    wr(1, 1, 64'd9999); idle(2, 0);
    step(0, 0, 0, 0, 0, 0, 2'b11); idle(2, 0);
    step(0, 0, 0, 1, 0, 0, 2'b01); idle(2, 0);
    step(0, 0, 0, 1, 0, 0, 2'b10); idle(2, 0);
    wr(1, 1, 64'd50); wr(0, 1, 64'd45); idle(4, 0);
    step(0, 0, 0, 1, 0, 0, 2'b01); idle(2, 0);

    phase = "R10";
    wr(1, 1, 64'h8000_0000_0000_00C8); wr(0, 1, 64'd190); idle(15, 0);
    wr(3, 1, 64'h8000_0000_0000_0002); wr(2, 1, 64'd0); idle(4, 1); idle(2, 0);

    compare_all();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule